// File: doc/BRIEF.md
# Addressed Asynchronous Serial Receiver

This block receives asynchronous serial frames on a single shared line and delivers only the bytes meant for this node. It samples the line with a 16x oversample tick and strips the start, data, optional parity, optional address-flag and stop bits from each frame. An address-flag bit of 1 marks the frame as a node address. A flag of 0 marks it as payload.

With filtering on, payload frames are dropped until an address frame matches the programmed node address. From then on payload is accepted, until an address frame arrives that does not match. Accepted bytes land in a data register, together with a full flag and a receive interrupt. Framing, parity and overrun faults set sticky flags that drive an error interrupt.

Top module: `mprx_rx`

## Requirements
- R1: After reset `rx_data` is 0x00, and `rx_full`, `rx_irq`, `err_irq`, `frm_err`, `par_err`, `ovr_err` and `id_hit` are all 0.
- R2: A frame is one low start bit, 8 data bits LSB first, a parity bit when `par_en`=1, an address-flag bit when `mp_en`=1, then a high stop bit, each 16 ticks long. The bits come in that order and each is sampled at its midpoint. A delivered byte appears on `rx_data` and sets `rx_full`, which `rx_irq` follows.
- R3: A start bit that is high again at its midpoint is discarded with no effect, and the receiver waits for the next falling edge.
- R4: A stop bit sampled low sets `frm_err` and `err_irq` and leaves `rx_data` and `rx_full` unchanged.
- R5: With `par_en`=1, the parity bit makes the count of ones over the data and parity bits even when `par_odd`=0 and odd when `par_odd`=1. A mismatch sets `par_err` and `err_irq`, and the byte is not delivered.
- R6: With `mp_en`=1 and `filt_en`=1, payload frames (flag 0) received before any matching address frame are dropped: `rx_full` stays 0.
- R7: An address frame (flag 1) whose byte equals `node_id` pulses `id_hit` high for one cycle and does not load `rx_data`. The payload frames that follow it are delivered.
- R8: An address frame whose byte differs from `node_id` gives no `id_hit`, and the payload frames after it are dropped until a matching address frame arrives.
- R9: A byte that is due for delivery while `rx_full` is 1 sets `ovr_err` and `err_irq`, and `rx_data` keeps the older byte.
- R10: A one-cycle pulse on `clr_full` clears `rx_full`. A pulse on `clr_err` clears `frm_err`, `par_err` and `ovr_err`.
- R11: With `filt_en`=0 every error-free frame is delivered, whatever its flag, and `id_hit` stays 0.
- R12: With `mp_en`=0 the frame has no address-flag bit, and every error-free frame is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversample enable, 16 per bit |
| rx_in | input | 1 | Serial line, idle high |
| node_id | input | 8 | Address of this node |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| mp_en | input | 1 | Address-flag bit present |
| filt_en | input | 1 | Enable address filtering |
| clr_full | input | 1 | Clear the full flag |
| clr_err | input | 1 | Clear the error flags |
| rx_data | output | 8 | Last delivered byte |
| rx_full | output | 1 | Unread byte present |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |
| frm_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |
| ovr_err | output | 1 | Overrun flag |
| id_hit | output | 1 | One-cycle pulse on an address match |

## Verification
The hardest state to reach from the ports is a drop of payload that was accepted earlier. The filter must be opened by a matching address, then closed again by a foreign address, and only the absence of any change on `rx_data` and `rx_full` shows that it closed. The directed sequence walks the filter through closed, open, closed and bypassed. It checks the outputs after every frame. A start glitch is placed directly in front of a valid frame, to show that the receiver resynchronises. A framing fault is placed so that the low stop bit itself looks like a start edge, which the glitch rejection must then absorb.

// File: rtl/mprx_pkg.sv
package mprx_pkg;
    localparam int unsigned DW    = 8;
    localparam int unsigned OSR   = 16;
    localparam int unsigned PH_W  = $clog2(OSR);
    localparam int unsigned IDX_W = $clog2(DW);

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_MPB, ST_STOP
    } dfr_st_e;

    typedef struct packed {
        dfr_st_e           st;
        logic [PH_W-1:0]   ph;
        logic [IDX_W-1:0]  idx;
        logic [DW-1:0]     shf;
        logic              par;
        logic              pbad;
        logic              mpb;
        logic              done;
        logic              ferr;
    } dfr_t;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          full;
        logic          acc;
        logic          hit;
        logic          ferr;
        logic          perr;
        logic          ovr;
    } flt_t;
endpackage

// File: rtl/mprx_sync.sv
module mprx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/mprx_deframer.sv
module mprx_deframer
    import mprx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rx,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          mp_en,
    output logic          fr_done,
    output logic [DW-1:0] fr_byte,
    output logic          fr_mpb,
    output logic          fr_ferr,
    output logic          fr_perr
);
    localparam logic [PH_W-1:0]  PH_MID  = PH_W'(OSR/2 - 1);
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(OSR - 1);
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(DW - 1);

    dfr_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (tick) begin
            case (q.st)
                ST_IDLE: begin
                    if (!rx) begin
                        d.st = ST_START;
                        d.ph = '0;
                    end
                end
                ST_START: begin
                    if (q.ph == PH_MID) begin
                        d.ph   = '0;
                        d.idx  = '0;
                        d.par  = 1'b0;
                        d.pbad = 1'b0;
                        d.mpb  = 1'b0;
                        d.st   = rx ? ST_IDLE : ST_DATA;
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (q.ph == PH_LAST) begin
                        d.ph  = '0;
                        d.shf = {rx, q.shf[DW-1:1]};
                        d.par = q.par ^ rx;
                        if (q.idx == IDX_TOP) begin
                            if (par_en)     d.st = ST_PAR;
                            else if (mp_en) d.st = ST_MPB;
                            else            d.st = ST_STOP;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (q.ph == PH_LAST) begin
                        d.ph   = '0;
                        d.pbad = (q.par ^ rx) != par_odd;
                        d.st   = mp_en ? ST_MPB : ST_STOP;
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
                ST_MPB: begin
                    if (q.ph == PH_LAST) begin
                        d.ph  = '0;
                        d.mpb = rx;
                        d.st  = ST_STOP;
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (q.ph == PH_LAST) begin
                        d.ph   = '0;
                        d.done = 1'b1;
                        d.ferr = !rx;
                        d.st   = ST_IDLE;
                    end else begin
                        d.ph = q.ph + 1'b1;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign fr_done = q.done;
    assign fr_byte = q.shf;
    assign fr_mpb  = q.mpb;
    assign fr_ferr = q.ferr;
    assign fr_perr = q.pbad;
endmodule

// File: rtl/mprx_filter.sv
module mprx_filter
    import mprx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fr_done,
    input  logic [DW-1:0] fr_byte,
    input  logic          fr_mpb,
    input  logic          fr_ferr,
    input  logic          fr_perr,
    input  logic [DW-1:0] node_id,
    input  logic          mp_en,
    input  logic          filt_en,
    input  logic          clr_full,
    input  logic          clr_err,
    output logic [DW-1:0] rx_data,
    output logic          rx_full,
    output logic          rx_irq,
    output logic          err_irq,
    output logic          frm_err,
    output logic          par_err,
    output logic          ovr_err,
    output logic          id_hit
);
    flt_t q, d;
    logic deliver;

    always_comb begin
        d       = q;
        d.hit   = 1'b0;
        deliver = 1'b0;
        if (clr_full) d.full = 1'b0;
        if (clr_err) begin
            d.ferr = 1'b0;
            d.perr = 1'b0;
            d.ovr  = 1'b0;
        end
        if (fr_done) begin
            if (fr_ferr || fr_perr) begin
                if (fr_ferr) d.ferr = 1'b1;
                if (fr_perr) d.perr = 1'b1;
            end else if (mp_en && filt_en) begin
                if (fr_mpb) begin
                    d.acc = (fr_byte == node_id);
                    d.hit = (fr_byte == node_id);
                end else begin
                    deliver = q.acc;
                end
            end else begin
                deliver = 1'b1;
            end
        end
        if (deliver) begin
            if (q.full && !clr_full) begin
                d.ovr = 1'b1;
            end else begin
                d.data = fr_byte;
                d.full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_data = q.data;
    assign rx_full = q.full;
    assign rx_irq  = q.full;
    assign frm_err = q.ferr;
    assign par_err = q.perr;
    assign ovr_err = q.ovr;
    assign err_irq = q.ferr | q.perr | q.ovr;
    assign id_hit  = q.hit;
endmodule

// File: rtl/mprx_rx.sv
module mprx_rx
    import mprx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          rx_in,
    input  logic [DW-1:0] node_id,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          mp_en,
    input  logic          filt_en,
    input  logic          clr_full,
    input  logic          clr_err,
    output logic [DW-1:0] rx_data,
    output logic          rx_full,
    output logic          rx_irq,
    output logic          err_irq,
    output logic          frm_err,
    output logic          par_err,
    output logic          ovr_err,
    output logic          id_hit
);
    logic          rx_s;
    logic          fr_done;
    logic [DW-1:0] fr_byte;
    logic          fr_mpb;
    logic          fr_ferr;
    logic          fr_perr;

    mprx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_in), .dout(rx_s)
    );

    mprx_deframer u_dfr (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s),
        .par_en(par_en), .par_odd(par_odd), .mp_en(mp_en),
        .fr_done(fr_done), .fr_byte(fr_byte), .fr_mpb(fr_mpb),
        .fr_ferr(fr_ferr), .fr_perr(fr_perr)
    );

    mprx_filter u_flt (
        .clk(clk), .rst_n(rst_n), .fr_done(fr_done), .fr_byte(fr_byte),
        .fr_mpb(fr_mpb), .fr_ferr(fr_ferr), .fr_perr(fr_perr),
        .node_id(node_id), .mp_en(mp_en), .filt_en(filt_en),
        .clr_full(clr_full), .clr_err(clr_err),
        .rx_data(rx_data), .rx_full(rx_full), .rx_irq(rx_irq),
        .err_irq(err_irq), .frm_err(frm_err), .par_err(par_err),
        .ovr_err(ovr_err), .id_hit(id_hit)
    );
endmodule

// File: rtl/mprx_rx_chk.sv
module mprx_rx_chk
    import mprx_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] rx_data,
    input logic          rx_full,
    input logic          clr_full,
    input logic          id_hit,
    input logic          fr_done,
    input logic          fr_ferr,
    input logic          frm_err
);
    a_r9_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full && !clr_full |=> $stable(rx_data));

    a_r7_hit_single: assert property (@(posedge clk) disable iff (!rst_n)
        id_hit |=> !id_hit);

    a_r7_id_not_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        id_hit |-> $stable(rx_data));

    a_r2_load_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_data != $past(rx_data)) |-> rx_full);

    a_r10_clear_full: assert property (@(posedge clk) disable iff (!rst_n)
        clr_full && !fr_done |=> !rx_full);

    a_r4_ferr_no_load: assert property (@(posedge clk) disable iff (!rst_n)
        fr_done && fr_ferr |=> frm_err && $stable(rx_data));
endmodule

bind mprx_rx mprx_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_full(rx_full),
    .clr_full(clr_full), .id_hit(id_hit), .fr_done(fr_done),
    .fr_ferr(fr_ferr), .frm_err(frm_err)
);

// File: tb/mprx_rx_bench.sv
`timescale 1ns/1ps
module mprx_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       rx_in = 1'b1;
    logic [7:0] node_id = 8'h5A;
    logic       par_en = 1'b0, par_odd = 1'b0, mp_en = 1'b1, filt_en = 1'b1;
    logic       clr_full = 1'b0, clr_err = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, rx_irq, err_irq, frm_err, par_err, ovr_err, id_hit;

    int checks = 0, errors = 0, hits = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    mprx_rx u_mprx_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
        .node_id(node_id), .par_en(par_en), .par_odd(par_odd),
        .mp_en(mp_en), .filt_en(filt_en), .clr_full(clr_full),
        .clr_err(clr_err), .rx_data(rx_data), .rx_full(rx_full),
        .rx_irq(rx_irq), .err_irq(err_irq), .frm_err(frm_err),
        .par_err(par_err), .ovr_err(ovr_err), .id_hit(id_hit)
    );

    always @(posedge clk) if (rst_n && id_hit) hits++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic hold_bit(input logic v);
        rx_in = v;
        repeat (16) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input logic mpb,
                              input logic flip_par, input logic stop_v);
        @(negedge clk);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(b[i]);
        if (par_en) hold_bit((^b) ^ par_odd ^ flip_par);
        if (mp_en)  hold_bit(mpb);
        hold_bit(stop_v);
        rx_in = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    task automatic pulse_clr(input logic f, input logic e);
        @(negedge clk);
        clr_full = f; clr_err = e;
        @(negedge clk);
        clr_full = 0; clr_err = 0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 rx_data", rx_data, 8'h00);
        chk("R1 rx_full", rx_full, 0);
        chk("R1 rx_irq", rx_irq, 0);
        chk("R1 err_irq", err_irq, 0);
        chk("R1 flags", {frm_err, par_err, ovr_err, id_hit}, 0);
    endtask

    task automatic t_closed();
        send_frame(8'h33, 0, 0, 1);
        chk("R6 payload dropped full", rx_full, 0);
        chk("R6 payload dropped data", rx_data, 8'h00);
    endtask

    task automatic t_mismatch(input logic [7:0] id, input logic [7:0] exp_d);
        int h0 = hits;
        send_frame(id, 1, 0, 1);
        chk("R8 no hit", hits - h0, 0);
        send_frame(8'h44, 0, 0, 1);
        chk("R8 skipped full", rx_full, 0);
        chk("R8 skipped data", rx_data, exp_d);
    endtask

    task automatic t_match();
        int h0 = hits;
        send_frame(8'h5A, 1, 0, 1);
        chk("R7 one hit pulse", hits - h0, 1);
        chk("R7 id not loaded", rx_data, 8'h00);
        chk("R7 id not full", rx_full, 0);
    endtask

    task automatic t_data();
        send_frame(8'hA5, 0, 0, 1);
        chk("R2 data", rx_data, 8'hA5);
        chk("R2 full", rx_full, 1);
        chk("R2 irq", rx_irq, 1);
    endtask

    task automatic t_overrun();
        send_frame(8'h3C, 0, 0, 1);
        chk("R9 ovr", ovr_err, 1);
        chk("R9 err_irq", err_irq, 1);
        chk("R9 data kept", rx_data, 8'hA5);
        pulse_clr(1, 1);
        chk("R10 full cleared", rx_full, 0);
        chk("R10 ovr cleared", ovr_err, 0);
        chk("R10 err_irq cleared", err_irq, 0);
        send_frame(8'h81, 0, 0, 1);
        chk("R7 follow-on payload", rx_data, 8'h81);
        pulse_clr(1, 0);
    endtask

    task automatic t_frame_err();
        send_frame(8'h77, 0, 0, 0);
        chk("R4 frm_err", frm_err, 1);
        chk("R4 err_irq", err_irq, 1);
        chk("R4 not full", rx_full, 0);
        chk("R4 data kept", rx_data, 8'h81);
        pulse_clr(0, 1);
        chk("R10 frm cleared", frm_err, 0);
    endtask

    task automatic t_parity();
        par_en = 1; par_odd = 0;
        send_frame(8'h0F, 0, 1, 1);
        chk("R5 even mismatch", par_err, 1);
        chk("R5 not full", rx_full, 0);
        pulse_clr(0, 1);
        par_odd = 1;
        send_frame(8'h07, 0, 0, 1);
        chk("R5 odd good data", rx_data, 8'h07);
        chk("R5 odd good no err", par_err, 0);
        pulse_clr(1, 0);
        par_en = 0; par_odd = 0;
    endtask

    task automatic t_glitch();
        @(negedge clk);
        rx_in = 0;
        repeat (4) @(negedge clk);
        rx_in = 1;
        repeat (30) @(negedge clk);
        chk("R3 glitch ignored", {rx_full, err_irq}, 0);
        send_frame(8'h69, 0, 0, 1);
        chk("R3 resync data", rx_data, 8'h69);
        chk("R3 resync no err", err_irq, 0);
        pulse_clr(1, 0);
    endtask

    task automatic t_bypass();
        int h0 = hits;
        filt_en = 0;
        send_frame(8'h12, 0, 0, 1);
        chk("R11 payload delivered", rx_data, 8'h12);
        pulse_clr(1, 0);
        send_frame(8'h99, 1, 0, 1);
        chk("R11 flagged delivered", rx_data, 8'h99);
        chk("R11 flagged full", rx_full, 1);
        chk("R11 no hit", hits - h0, 0);
        pulse_clr(1, 0);
        filt_en = 1;
    endtask

    task automatic t_no_flag();
        mp_en = 0;
        send_frame(8'hC3, 0, 0, 1);
        chk("R12 delivered", rx_data, 8'hC3);
        chk("R12 no err", err_irq, 0);
        mp_en = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_closed();
        t_mismatch(8'h11, 8'h00);
        t_match();
        t_data();
        t_overrun();
        t_frame_err();
        t_parity();
        t_glitch();
        t_mismatch(8'h22, 8'h69);
        t_bypass();
        t_no_flag();
        finish_run();
    end
endmodule